// File: doc/BRIEF.md
# Clock Replacement Victim Selector

This block chooses which resident page frame to evict when a page fault occurs. It uses the clock policy. The frames are treated as a ring, and a hand register marks the next frame to consider. Each frame has a reference flag. Any access to a frame raises that flag. The hand position and all the flags persist from one fault to the next, so the frame chosen depends on the history of accesses and of earlier sweeps.

A fault request starts a sweep. The sweep inspects one frame per clock cycle, starting at the frame under the hand. If that frame's flag is raised, the sweep lowers the flag, moves the hand on and inspects the next frame. If the flag is low, that frame becomes the victim. The block then presents the victim index with a one-cycle done pulse. At the same moment it raises the victim's flag, because the incoming page counts as freshly referenced, and it moves the hand one place past the victim.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset the hand sits at frame 0, every reference flag is low, `busy` is 0 and `victim_valid` is 0. A fault issued immediately after reset selects frame 0.
- R2: A cycle with `ref_valid` high raises the reference flag of frame `ref_idx`. An index at or above `NUM_FRAMES` changes nothing.
- R3: A fault request sampled while `busy` is 0 makes `busy` 1 in the next cycle. A fault request sampled while `busy` is 1 is ignored and produces no extra result.
- R4: The first frame a sweep inspects is the one under the hand. A frame whose flag is low when inspected is reported as the victim.
- R5: A frame whose flag is high when inspected has its flag lowered. The hand then moves to the next frame, with frame `NUM_FRAMES-1` followed by frame 0. This costs one cycle per frame.
- R6: After a victim is reported, `hand_idx` equals the victim index plus one, modulo `NUM_FRAMES`. The hand never leaves the range 0 to `NUM_FRAMES-1`.
- R7: The victim's reference flag is high after it is reported.
- R8: `victim_valid` is a single-cycle pulse. When no references arrive during the sweep, it appears exactly k+2 clock edges after the fault request is sampled, where k is the number of frames whose flags were lowered. This is at most `NUM_FRAMES`+2 edges.
- R9: If a reference targets the frame whose flag the sweep lowers in that same cycle, the lowering wins.
- R10: A reference arriving during a sweep to a frame the hand has already passed raises that flag. The sweep then lowers it again when it comes round, and selects the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | A frame is being accessed this cycle |
| ref_idx | input | IDX_W | Index of the accessed frame |
| fault_req | input | 1 | Request to select a victim |
| busy | output | 1 | Sweep in progress |
| victim_valid | output | 1 | One-cycle pulse marking the result |
| victim_idx | output | IDX_W | Selected frame, valid with `victim_valid` |
| hand_idx | output | IDX_W | Current hand position |

## Verification
The bench uses five frames, so the hand wraps at a boundary that is not a power of two. It runs every one of the 32 patterns of accesses, each followed by a fault, against an arithmetic model that carries the hand and the flags from one fault to the next. This separates a correct second pass from a sweep that ignores flags, misses a clear or restarts at frame 0. The model also predicts the latency of every sweep, which exposes an extra cycle or a skipped step. Directed cases cover three more situations: a reference that collides with the clear under the hand, a reference behind the hand in mid-sweep, and a repeated fault during a sweep. Between them they tell apart the priority of clear over set, the re-raising of a passed flag, and the rejection of a new request while busy.

// File: rtl/clock_sel_pkg.sv
package clock_sel_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } sweep_st_e;

    // ring successor of frame i in a ring of n frames
    function automatic int unsigned ring_next(int unsigned i, int unsigned n);
        return (i + 1 >= n) ? 0 : i + 1;
    endfunction

endpackage

// File: rtl/clock_ref_flags.sv
module clock_ref_flags #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic [IDX_W-1:0]      set_idx,
    input  logic                  clr_en,
    input  logic                  pick_en,
    input  logic [IDX_W-1:0]      sweep_idx,
    output logic [NUM_FRAMES-1:0] flags
);

    logic [NUM_FRAMES-1:0] flag_d, flag_q;

    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_flag
        logic at_sweep;
        logic at_set;
        always_comb begin
            at_sweep  = (sweep_idx == IDX_W'(i));
            at_set    = set_en && (set_idx == IDX_W'(i));
            flag_d[i] = flag_q[i];
            if (at_set || (pick_en && at_sweep)) begin
                flag_d[i] = 1'b1;
            end
            // the sweep's clear has priority over an access in the same cycle
            if (clr_en && at_sweep) begin
                flag_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flags = flag_q;

endmodule

// File: rtl/clock_sweep_ctrl.sv
module clock_sweep_ctrl
    import clock_sel_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fault_req,
    input  logic [NUM_FRAMES-1:0] flags,
    output logic                  clr_en,
    output logic                  pick_en,
    output logic [IDX_W-1:0]      hand,
    output logic                  busy,
    output logic                  done,
    output logic [IDX_W-1:0]      victim
);

    typedef struct packed {
        sweep_st_e        st;
        logic [IDX_W-1:0] hand;
        logic             done;
        logic [IDX_W-1:0] victim;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic [IDX_W-1:0] hand_inc;

    always_comb begin
        hand_inc  = IDX_W'(ring_next(int'(ctl_q.hand), NUM_FRAMES));
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        clr_en     = 1'b0;
        pick_en    = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (fault_req) begin
                    ctl_d.st = ST_SWEEP;
                end
            end
            ST_SWEEP: begin
                if (flags[ctl_q.hand]) begin
                    clr_en     = 1'b1;
                    ctl_d.hand = hand_inc;
                end else begin
                    pick_en      = 1'b1;
                    ctl_d.done   = 1'b1;
                    ctl_d.victim = ctl_q.hand;
                    ctl_d.hand   = hand_inc;
                    ctl_d.st     = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, hand: '0, done: 1'b0, victim: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign hand   = ctl_q.hand;
    assign busy   = (ctl_q.st == ST_SWEEP);
    assign done   = ctl_q.done;
    assign victim = ctl_q.victim;

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
    parameter  int NUM_FRAMES = 8,
    localparam int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_idx,
    input  logic             fault_req,
    output logic             busy,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_idx,
    output logic [IDX_W-1:0] hand_idx
);

    logic [NUM_FRAMES-1:0] ref_flags;
    logic                  sweep_clr;
    logic                  sweep_pick;

    clock_sweep_ctrl #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_req (fault_req),
        .flags     (ref_flags),
        .clr_en    (sweep_clr),
        .pick_en   (sweep_pick),
        .hand      (hand_idx),
        .busy      (busy),
        .done      (victim_valid),
        .victim    (victim_idx)
    );

    clock_ref_flags #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (ref_valid),
        .set_idx   (ref_idx),
        .clr_en    (sweep_clr),
        .pick_en   (sweep_pick),
        .sweep_idx (hand_idx),
        .flags     (ref_flags)
    );

endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk
    import clock_sel_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  fault_req,
    input logic                  busy,
    input logic                  victim_valid,
    input logic [IDX_W-1:0]      victim_idx,
    input logic [IDX_W-1:0]      hand_idx,
    input logic [NUM_FRAMES-1:0] ref_flags
);

    // R3
    start_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fault_req) |=> busy);

    // R4
    pick_clear_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ref_flags[hand_idx]) |=> (victim_valid && victim_idx == $past(hand_idx)));

    // R5
    second_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ref_flags[hand_idx]) |=> (!ref_flags[$past(hand_idx)] && !victim_valid && busy));

    // R6
    hand_after_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> (hand_idx == IDX_W'(ring_next(int'(victim_idx), NUM_FRAMES))));

    // R6
    hand_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(hand_idx) < NUM_FRAMES);

    // R7
    victim_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> ref_flags[victim_idx]);

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |=> !victim_valid);

endmodule

bind clock_victim_sel clock_victim_sel_chk #(
    .NUM_FRAMES (NUM_FRAMES),
    .IDX_W      (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_req    (fault_req),
    .busy         (busy),
    .victim_valid (victim_valid),
    .victim_idx   (victim_idx),
    .hand_idx     (hand_idx),
    .ref_flags    (ref_flags)
);

// File: tb/clock_victim_sel_bench.sv
module clock_victim_sel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 5;
    localparam int IW         = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_valid = 1'b0;
    logic [IW-1:0] ref_idx = '0;
    logic          fault_req = 1'b0;
    logic          busy;
    logic          victim_valid;
    logic [IW-1:0] victim_idx;
    logic [IW-1:0] hand_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // reference model
    bit m_r [N];
    int m_hand;

    always #(CLK_PERIOD/2) clk = ~clk;

    clock_victim_sel #(.NUM_FRAMES(N)) u_clock_victim_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_valid    (ref_valid),
        .ref_idx      (ref_idx),
        .fault_req    (fault_req),
        .busy         (busy),
        .victim_valid (victim_valid),
        .victim_idx   (victim_idx),
        .hand_idx     (hand_idx)
    );

    task automatic check(string req, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic touch(int idx);
        ref_valid = 1'b1;
        ref_idx   = IW'(idx);
        @(negedge clk);
        ref_valid = 1'b0;
        if (idx < N) m_r[idx] = 1'b1;
    endtask

    // issue a fault and return the victim and the edge count until the pulse
    task automatic fault(bit hold_extra, output int vic, output int edges);
        fault_req = 1'b1;
        @(negedge clk);
        edges = 1;
        if (!hold_extra) fault_req = 1'b0;
        while (!victim_valid && edges < 4*N + 8) begin
            @(negedge clk);
            fault_req = 1'b0;
            edges++;
        end
        fault_req = 1'b0;
        vic = int'(victim_idx);
    endtask

    function automatic void model_fault(output int vic, output int clears);
        clears = 0;
        while (m_r[m_hand]) begin
            m_r[m_hand] = 1'b0;
            m_hand = (m_hand + 1) % N;
            clears++;
        end
        vic = m_hand;
        m_r[m_hand] = 1'b1;
        m_hand = (m_hand + 1) % N;
    endfunction

    initial begin
        int vic, edges, e_vic, e_clr, h0;
        for (int i = 0; i < N; i++) m_r[i] = 1'b0;
        m_hand = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 hand", int'(hand_idx), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 valid", int'(victim_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: first fault after reset takes frame 0 at once
        fault(1'b0, vic, edges);
        model_fault(e_vic, e_clr);
        check("R1 victim", vic, 0);
        check("R8 latency", edges, 2);

        // R2 R4 R5 R6 R7 R8: all access patterns, state carried by the model
        for (int mask = 0; mask < (1 << N); mask++) begin
            for (int f = 0; f < N; f++) if (mask[f]) touch(f);
            touch(N + (mask % 3));              // R2 out-of-range index is ignored
            fault(mask[0], vic, edges);         // R3 repeated request on odd masks
            model_fault(e_vic, e_clr);
            check("R4 R7 victim", vic, e_vic);
            check("R5 R8 latency", edges, e_clr + 2);
            @(negedge clk);
            check("R6 hand", int'(hand_idx), m_hand);
            check("R3 no extra result", int'(victim_valid) + int'(busy), 0);
        end

        // R9: access to the hand frame in the cycle it is cleared
        for (int f = 0; f < N; f++) touch(f);
        h0 = m_hand;
        fault_req = 1'b1;
        @(negedge clk);
        fault_req = 1'b0;
        ref_valid = 1'b1;
        ref_idx   = IW'(h0);
        @(negedge clk);
        ref_valid = 1'b0;
        edges = 2;
        while (!victim_valid && edges < 4*N + 8) begin
            @(negedge clk);
            edges++;
        end
        check("R9 victim", int'(victim_idx), h0);
        check("R9 latency", edges, N + 2);
        for (int i = 0; i < N; i++) m_r[i] = (i == h0);
        m_hand = (h0 + 1) % N;

        // R10: access behind the hand during a sweep
        for (int f = 0; f < N; f++) touch(f);
        h0 = m_hand;
        fault_req = 1'b1;
        @(negedge clk);
        fault_req = 1'b0;
        @(negedge clk);                         // first frame cleared at this edge
        ref_valid = 1'b1;
        ref_idx   = IW'(h0);
        @(negedge clk);
        ref_valid = 1'b0;
        edges = 3;
        while (!victim_valid && edges < 4*N + 8) begin
            @(negedge clk);
            edges++;
        end
        check("R10 victim", int'(victim_idx), (h0 + 1) % N);
        check("R10 latency", edges, N + 3);
        for (int i = 0; i < N; i++) m_r[i] = (i == (h0 + 1) % N);
        m_hand = (h0 + 2) % N;

        // R7: the marked victim is skipped last on a full revolution
        for (int f = 0; f < N; f++) if (!m_r[f]) touch(f);
        fault(1'b0, vic, edges);
        model_fault(e_vic, e_clr);
        check("R7 victim", vic, e_vic);
        check("R7 latency", edges, e_clr + 2);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule